// File: doc/BRIEF.md
# Accumulator Operate and Shift Unit

This block is the accumulator and link datapath for the operate class and the rotate/shift class of a 16-bit minicomputer. It holds a 16-bit accumulator and a one-bit link. A sequencer presents an instruction word together with a one-cycle valid strobe, and a 16-bit front-panel switch value. The block decodes the word and updates its state on that clock edge. In the following cycle it raises a one-cycle completion pulse. A halt indication rides along with that pulse when the word is a halt.

Operate words carry independent micro-operation bits. When several of them are set in one word, they apply in three fixed sub-phases: first the clears, then the complements, then the increment and the switch merge. This ordering lets combined words such as "clear then complement" or "complement then increment" build constants and negations in one instruction. Shift words rotate through the link, or shift the accumulator arithmetically, by one to three places.

Top module: `acc_microop_unit`

## Requirements
- R1: While reset is low, and right after it, the accumulator is 0, the link is 0, and both the completion and halt outputs are low.
- R2: A word is sampled only on a rising edge with the valid strobe high. The new state is visible after that edge, together with a completion pulse that lasts exactly one cycle. With the strobe low, the accumulator and link keep their values.
- R3: A word whose bits 14 to 6 are all zero is an operate word. In its first sub-phase, bit 0 clears the accumulator and bit 3 clears the link.
- R4: In the second sub-phase, which acts on the result of the first, bit 1 inverts the accumulator and bit 4 inverts the link.
- R5: In the third sub-phase, bit 2 adds one to the accumulator. A carry out of bit 15 inverts the link. Word 0o100006 therefore yields the two's complement of the accumulator.
- R6: Also in the third sub-phase, after the increment, bit 5 ORs the switch value into the accumulator.
- R7: An operate word with bits 5 to 0 all zero is a halt when bit 15 is clear. The halt output is then high in the same cycle as the completion pulse, and the state does not change. With bit 15 set, the same word is a no-operation and no halt is reported.
- R8: A shift word has bits 15 to 6 equal to octal 030 and bits 3 to 2 equal to zero. Bits 1 to 0 give a count of 1 to 3. Bits 5 to 4 select the operation: 0 rotate left, 1 rotate right, 2 arithmetic shift left, 3 arithmetic shift right.
- R9: Rotates treat the link (as the most significant bit) and the accumulator as one 17-bit ring, and turn it by the count.
- R10: Arithmetic shift left keeps bit 15 as it was. It moves bits 14 to 0 left by the count, fills the vacated places with zeros and drops the bits shifted out. The link is unchanged.
- R11: Arithmetic shift right copies bit 15 into every vacated position. The link is unchanged.
- R12: A shift word with count 0, or any word that is neither an operate nor a shift word, leaves the accumulator and link unchanged. It still produces a completion pulse, without halt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | One-cycle strobe: instrWord is to be executed |
| instrWord | input | 16 | Instruction word |
| switchIn | input | 16 | Front-panel switch value for the OR micro-operation |
| accOut | output | 16 | Accumulator |
| linkOut | output | 1 | Link bit |
| done | output | 1 | One-cycle pulse after an executed word |
| halt | output | 1 | High with done when the word was a halt |

## Verification
Combined operate words are the main concern, because only combinations show whether the sub-phase order is right. Clear-then-complement must give all ones, not zero. Complement-then-increment must negate, and increment-then-OR differs from OR-then-increment when the switch value has bit 0 set. Increment is tried both on all ones, where the carry must flip the link, and on an ordinary value, where it must not. Each shift kind is tried with counts 1 and 3, on values whose sign bit and link differ. This separates a 17-bit rotate from a 16-bit one, and a sign-keeping shift from a logical one. Count 0 and out-of-group words check that nothing changes.

// File: rtl/acc_microop_pkg.sv
package acc_microop_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_SHIFT = 3;
  localparam int CNT_W     = $clog2(MAX_SHIFT + 1);

  typedef enum logic [1:0] {
    SH_ROT_LEFT  = 2'd0,
    SH_ROT_RIGHT = 2'd1,
    SH_ARI_LEFT  = 2'd2,
    SH_ARI_RIGHT = 2'd3
  } shiftKind_e;

  typedef struct packed {
    logic       loadMicro;
    logic       loadShift;
    logic       clrAcc;
    logic       clrLink;
    logic       cmpAcc;
    logic       cmpLink;
    logic       incAcc;
    logic       orSwitch;
    shiftKind_e shKind;
    logic [CNT_W-1:0] shCount;
  } ctrlStrobes_t;
endpackage

// File: rtl/acc_microop_ctrl.sv
module acc_microop_ctrl
  import acc_microop_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [WORD_W-1:0] instrWord,
  output ctrlStrobes_t      strobes,
  output logic              doneQ,
  output logic              haltQ
);
  localparam logic [WORD_W-1:0] MICRO_MASK  = 16'o077700;
  localparam logic [9:0]        SHIFT_GROUP = 10'o030;

  logic isMicro;
  logic isShift;
  logic isHalt;

  always_comb begin
    isMicro = (instrWord & MICRO_MASK) == '0;
    isShift = (instrWord[15:6] == SHIFT_GROUP) && (instrWord[3:2] == 2'b00)
              && (instrWord[1:0] != 2'b00);
    isHalt  = isMicro && (instrWord[5:0] == 6'd0) && !instrWord[15];

    strobes.loadMicro = instrValid && isMicro;
    strobes.loadShift = instrValid && isShift;
    strobes.clrAcc    = instrWord[0];
    strobes.cmpAcc    = instrWord[1];
    strobes.incAcc    = instrWord[2];
    strobes.clrLink   = instrWord[3];
    strobes.cmpLink   = instrWord[4];
    strobes.orSwitch  = instrWord[5];
    strobes.shKind    = shiftKind_e'(instrWord[5:4]);
    strobes.shCount   = CNT_W'(instrWord[1:0]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneQ <= 1'b0;
      haltQ <= 1'b0;
    end else begin
      doneQ <= instrValid;
      haltQ <= instrValid && isHalt;
    end
  end
endmodule

// File: rtl/acc_microop_datapath.sv
module acc_microop_datapath
  import acc_microop_pkg::*;
#(
  parameter int W = WORD_W,
  parameter int NSH = MAX_SHIFT
)(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [W-1:0] switchIn,
  output logic [W-1:0] accQ,
  output logic         linkQ
);
  localparam int RING_W = W + 1;

  logic [RING_W-1:0] ring;
  logic [RING_W-1:0] rotL [1:NSH];
  logic [RING_W-1:0] rotR [1:NSH];
  logic [W-1:0]      ariL [1:NSH];
  logic [W-1:0]      ariR [1:NSH];

  assign ring = {linkQ, accQ};

  for (genvar n = 1; n <= NSH; n++) begin : g_amount
    assign rotL[n] = {ring[RING_W-1-n:0], ring[RING_W-1:RING_W-n]};
    assign rotR[n] = {ring[n-1:0], ring[RING_W-1:n]};
    assign ariL[n] = {accQ[W-1], accQ[W-2-n:0], {n{1'b0}}};
    assign ariR[n] = {{n{accQ[W-1]}}, accQ[W-1:n]};
  end

  logic [W-1:0] phase1Acc, phase2Acc, phase3Sum, microAcc;
  logic         phase1Link, phase2Link, microLink, incCarry;

  always_comb begin
    phase1Acc  = strobes.clrAcc  ? '0   : accQ;
    phase1Link = strobes.clrLink ? 1'b0 : linkQ;
    phase2Acc  = strobes.cmpAcc  ? ~phase1Acc  : phase1Acc;
    phase2Link = strobes.cmpLink ? ~phase1Link : phase1Link;
    {incCarry, phase3Sum} = {1'b0, phase2Acc} + RING_W'(1);
    if (!strobes.incAcc) begin
      phase3Sum = phase2Acc;
      incCarry  = 1'b0;
    end
    microLink = phase2Link ^ incCarry;
    microAcc  = strobes.orSwitch ? (phase3Sum | switchIn) : phase3Sum;
  end

  logic [W-1:0] shiftAcc;
  logic         shiftLink;
  int unsigned  idx;

  always_comb begin
    idx = (int'(strobes.shCount) == 0) ? 1 : int'(strobes.shCount);
    shiftAcc  = accQ;
    shiftLink = linkQ;
    unique case (strobes.shKind)
      SH_ROT_LEFT:  {shiftLink, shiftAcc} = rotL[idx];
      SH_ROT_RIGHT: {shiftLink, shiftAcc} = rotR[idx];
      SH_ARI_LEFT:  shiftAcc = ariL[idx];
      SH_ARI_RIGHT: shiftAcc = ariR[idx];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      linkQ <= 1'b0;
    end else if (strobes.loadMicro) begin
      accQ  <= microAcc;
      linkQ <= microLink;
    end else if (strobes.loadShift) begin
      accQ  <= shiftAcc;
      linkQ <= shiftLink;
    end
  end
endmodule

// File: rtl/acc_microop_unit.sv
module acc_microop_unit
  import acc_microop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  input  logic [15:0] switchIn,
  output logic [15:0] accOut,
  output logic        linkOut,
  output logic        done,
  output logic        halt
);
  ctrlStrobes_t strobes;

  acc_microop_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .instrValid (instrValid),
    .instrWord  (instrWord),
    .strobes    (strobes),
    .doneQ      (done),
    .haltQ      (halt)
  );

  acc_microop_datapath #(.W(WORD_W), .NSH(MAX_SHIFT)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .switchIn (switchIn),
    .accQ     (accOut),
    .linkQ    (linkOut)
  );
endmodule

// File: rtl/acc_microop_chk.sv
module acc_microop_chk (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic [15:0] switchIn,
  input logic [15:0] accOut,
  input logic        linkOut,
  input logic        done,
  input logic        halt
);
  logic shiftWord;
  assign shiftWord = (instrWord[15:6] == 10'o030) && (instrWord[3:2] == 2'b00);

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrValid |=> done);

  // R2
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> !done);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !instrValid |=> ($stable(accOut) && $stable(linkOut)));

  // R7
  halt_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    halt |-> done);

  // R7
  halt_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord == 16'o000000) |=> (halt && $stable(accOut)));

  // R3
  clear_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && instrWord == 16'o100011) |=> (accOut == 16'd0 && !linkOut));

  // R10
  sign_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && shiftWord && instrWord[5:4] == 2'd2 && instrWord[1:0] != 2'd0)
      |=> (accOut[15] == $past(accOut[15]) && $stable(linkOut)));

  // R12
  zero_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && shiftWord && instrWord[1:0] == 2'd0)
      |=> ($stable(accOut) && $stable(linkOut) && !halt));
endmodule

bind acc_microop_unit acc_microop_chk i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .switchIn   (switchIn),
  .accOut     (accOut),
  .linkOut    (linkOut),
  .done       (done),
  .halt       (halt)
);

// File: tb/test_acc_microop_unit.sv
module test_acc_microop_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] switchIn = '0;
  logic [15:0] accOut;
  logic        linkOut;
  logic        done;
  logic        halt;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] acc;
    logic        link;
    logic        halt;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [15:0] mAcc = '0;
  logic        mLink = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_microop_unit i_acc_microop_unit (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .switchIn(switchIn), .accOut(accOut), .linkOut(linkOut), .done(done), .halt(halt)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [15:0] w, input logic [15:0] sw, output logic hl);
    logic [16:0] ring;
    logic [16:0] sum;
    int n;
    hl = 1'b0;
    if ((w & 16'o077700) == 16'd0) begin
      if (w[0]) mAcc = '0;
      if (w[3]) mLink = 1'b0;
      if (w[1]) mAcc = ~mAcc;
      if (w[4]) mLink = ~mLink;
      if (w[2]) begin
        sum = {1'b0, mAcc} + 17'd1;
        mAcc = sum[15:0];
        if (sum[16]) mLink = ~mLink;
      end
      if (w[5]) mAcc = mAcc | sw;
      hl = (w[5:0] == 6'd0) && !w[15];
    end else if (w[15:6] == 10'o030 && w[3:2] == 2'b00 && w[1:0] != 2'b00) begin
      n = int'(w[1:0]);
      ring = {mLink, mAcc};
      case (w[5:4])
        2'd0: for (int i = 0; i < n; i++) ring = {ring[15:0], ring[16]};
        2'd1: for (int i = 0; i < n; i++) ring = {ring[0], ring[16:1]};
        2'd2: ring[15:0] = {mAcc[15], 15'(mAcc[14:0] << n)};
        default: ring[15:0] = 16'($signed(mAcc) >>> n);
      endcase
      {mLink, mAcc} = ring;
    end
  endtask

  task automatic applyWord(input logic [15:0] w, input logic [15:0] sw, input string tag);
    expItem_t it;
    logic hl;
    model(w, sw, hl);
    it.acc = mAcc; it.link = mLink; it.halt = hl; it.tag = tag;
    expQ.push_back(it);
    instrWord = w; switchIn = sw; instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
    @(negedge clk);
    check(done == 1'b0, "R2 done lasts one cycle", 32'(done), 32'd0);
  endtask

  // Monitor: pop and compare on every completion pulse
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected done", 32'd1, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(accOut == e.acc, {e.tag, " acc"}, 32'(accOut), 32'(e.acc));
        check(linkOut == e.link, {e.tag, " link"}, 32'(linkOut), 32'(e.link));
        check(halt == e.halt, {e.tag, " halt"}, 32'(halt), 32'(e.halt));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(accOut == 16'd0 && linkOut == 1'b0, "R1 reset acc/link", {15'd0, linkOut, accOut}, 32'd0);
    check(done == 1'b0 && halt == 1'b0, "R1 reset done/halt", {30'd0, done, halt}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(accOut == 16'd0 && done == 1'b0, "R1 after reset", {15'd0, done, accOut}, 32'd0);

    applyWord(16'o100040, 16'h1234, "R6 OR switches");
    applyWord(16'o100002, 16'h0000, "R4 complement acc");
    applyWord(16'o100020, 16'h0000, "R4 complement link");
    applyWord(16'o100011, 16'h0000, "R3 clear acc and link");
    applyWord(16'o100003, 16'h0000, "R4 clear then complement");
    applyWord(16'o100004, 16'h0000, "R5 increment carry toggles link");
    applyWord(16'o100044, 16'h00F1, "R6 increment before OR");
    applyWord(16'o100006, 16'h0000, "R5 negate");
    applyWord(16'o100004, 16'h0000, "R5 increment without carry");
    applyWord(16'o100030, 16'h0000, "R4 set link");

    // R2 idle hold: state must not move without the strobe
    switchIn = 16'hFFFF; instrWord = 16'o100001;
    repeat (5) @(negedge clk);
    check(accOut == mAcc && linkOut == mLink, "R2 idle hold", {15'd0, linkOut, accOut}, {15'd0, mLink, mAcc});

    applyWord(16'o000000, 16'h0000, "R7 halt");
    applyWord(16'o100000, 16'h0000, "R7 no-op with bit 15 set");

    applyWord(16'o100011, 16'h0000, "R3 clear");
    applyWord(16'o100040, 16'hC005, "R6 load pattern");
    applyWord(16'o003001, 16'h0000, "R9 rotate left 1");
    applyWord(16'o003003, 16'h0000, "R9 rotate left 3");
    applyWord(16'o003021, 16'h0000, "R9 rotate right 1");
    applyWord(16'o003023, 16'h0000, "R9 rotate right 3");
    applyWord(16'o100040, 16'hA5A5, "R6 reload");
    applyWord(16'o003041, 16'h0000, "R10 shift left 1");
    applyWord(16'o003043, 16'h0000, "R10 shift left 3");
    applyWord(16'o003061, 16'h0000, "R11 shift right 1");
    applyWord(16'o003063, 16'h0000, "R11 shift right 3");
    applyWord(16'o100011, 16'h0000, "R3 clear");
    applyWord(16'o100040, 16'h4F01, "R6 positive value");
    applyWord(16'o003043, 16'h0000, "R10 positive shift left 3");
    applyWord(16'o003062, 16'h0000, "R11 positive shift right 2");
    applyWord(16'o003000, 16'h0000, "R12 count zero");
    applyWord(16'o003100, 16'h0000, "R12 outside shift group");
    applyWord(16'o003004, 16'h0000, "R8 nonzero bits 3..2 ignored");
    applyWord(16'o060077, 16'hFFFF, "R12 other class ignored");

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2 all results seen", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule